// File: doc/BRIEF.md
# Indexed Clock-Control Register Bank

This block is a byte-wide register bank for the clock section of a video controller. Software reaches it over a small I/O bus. One address selects a register number, a second address reads or writes the selected register, and a third pair of addresses (one for writing, another for reading) holds a miscellaneous output byte whose bits 3:2 choose the pixel clock source. The registers that set up the clocks are guarded by a lock register, and they open only while that register holds a fixed key value.

The bank holds divider settings for two PLLs. The memory-clock PLL takes new settings as soon as they are written. The pixel-clock PLL has a pending copy and an active copy. Writes change only the pending copy, and the active copy, which drives the PLL outputs, is loaded when software pulses a trigger bit low, then high, then low again. A further control bit enables the pixel clock and sync outputs. The analog PLLs and the video timing are outside this block, which only presents the divider fields and select lines to them.

Top module: `clkbank_regs`

## Requirements
- R1: A synchronous active-high reset locks the bank, clears the miscellaneous byte (clock select 0) and the index, sets register 0x0D to 0x01, sets register 0x15 to 0x00, and loads the pending and active dividers with their defaults (pixel N 0x42, pixel M 0x3D, memory N 0x22, memory M 0x3A).
- R2: A write to the index port (0x3C4) selects a register number, and a read of the index port returns it. Reads and writes at the data port (0x3C5) act on the selected register.
- R3: Register 0x08 can always be written and read. The bank is unlocked exactly while 0x08 holds 0x06, and any other value locks it again.
- R4: While the bank is locked, data-port writes to any index other than 0x08 change nothing, and data-port reads of those indices return 0x00. Indices that are not implemented (anything other than 0x08, 0x0D, 0x10, 0x11, 0x12, 0x13 and 0x15) read 0x00 even when unlocked.
- R5: The memory PLL N byte sits at index 0x10, with N1 in bits 4:0 and N2 in bits 6:5. The M byte sits at index 0x11, with M in bits 6:0. A written value reaches the memory divider outputs on the next cycle.
- R6: Writes to 0x12 (pixel N, same layout as the memory N byte) and 0x13 (pixel M) change only the pending values, which read back at those indices. The active pixel divider outputs do not change.
- R7: The active pixel divider takes the pending values when bit 5 of register 0x15 goes 0, then 1, then 0, and the copy happens on the write that clears the bit. A write that leaves bit 5 at 0, or leaves it at 1, copies nothing. Register 0x15 reads back as written.
- R8: Bit 7 of the four divider registers reads as 0, and writing to it has no effect.
- R9: The miscellaneous byte is written at 0x3C2 and read back at 0x3CC, and a read at 0x3C2 returns 0x00. The clock select output equals bits 3:2 of the byte. The PLL-select output is high only when that value is 3, and values 0 and 1 select fixed clocks.
- R10: The output-drive enable is high exactly when bit 0 of register 0x0D is 0. Register 0x0D reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | ADDR_W | I/O address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address (combinational) |
| clk_sel | output | 2 | Clock source select |
| pll_selected | output | 1 | High when the programmable PLL is the source |
| drive_en | output | 1 | Enable for the pixel clock and sync outputs |
| pix_n1 | output | 5 | Active pixel PLL N1 |
| pix_n2 | output | 2 | Active pixel PLL N2 |
| pix_m | output | 7 | Active pixel PLL M |
| mem_n1 | output | 5 | Memory PLL N1 |
| mem_n2 | output | 2 | Memory PLL N2 |
| mem_m | output | 7 | Memory PLL M |

## Verification
The bench builds the block with its default parameters: a 10-bit address, the standard port addresses, key 0x06 and the reset divider values listed above. With these values the reset state can be checked against fixed numbers, and the bench can run the lock key and near-miss values such as 0x07 and 0x00. It also covers trigger sequences on bit 5 that should and should not copy the dividers, including a trigger attempted while locked. At every clock, a behavioural model of the bank predicts the read data and all outputs.

// File: rtl/clkbank_pkg.sv
package clkbank_pkg;

    localparam logic [7:0] IDX_LOCK  = 8'h08;
    localparam logic [7:0] IDX_CTL   = 8'h0D;
    localparam logic [7:0] IDX_MEM_N = 8'h10;
    localparam logic [7:0] IDX_MEM_M = 8'h11;
    localparam logic [7:0] IDX_PIX_N = 8'h12;
    localparam logic [7:0] IDX_PIX_M = 8'h13;
    localparam logic [7:0] IDX_TRIG  = 8'h15;
    localparam int         TRIG_BIT  = 5;
    localparam int         DIV_W     = 7;

    typedef struct packed {
        logic idx;
        logic misc;
        logic lock;
        logic ctl;
        logic mem_n;
        logic mem_m;
        logic pix_n;
        logic pix_m;
        logic trig;
    } wsel_t;

endpackage

// File: rtl/clkbank_decode.sv
module clkbank_decode
    import clkbank_pkg::*;
#(
    parameter int                ADDR_W       = 10,
    parameter logic [ADDR_W-1:0] IDX_PORT     = 'h3C4,
    parameter logic [ADDR_W-1:0] DATA_PORT    = 'h3C5,
    parameter logic [ADDR_W-1:0] MISC_WR_PORT = 'h3C2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        idx,
    input  logic              unlocked,
    output wsel_t             wsel
);

    logic data_wr;

    always_comb begin
        wsel     = '0;
        data_wr  = wr && (addr == DATA_PORT);
        wsel.idx  = wr && (addr == IDX_PORT);
        wsel.misc = wr && (addr == MISC_WR_PORT);
        wsel.lock = data_wr && (idx == IDX_LOCK);
        if (data_wr && unlocked) begin
            case (idx)
                IDX_CTL:   wsel.ctl   = 1'b1;
                IDX_MEM_N: wsel.mem_n = 1'b1;
                IDX_MEM_M: wsel.mem_m = 1'b1;
                IDX_PIX_N: wsel.pix_n = 1'b1;
                IDX_PIX_M: wsel.pix_m = 1'b1;
                IDX_TRIG:  wsel.trig  = 1'b1;
                default:   ;
            endcase
        end
    end

    // R2: at most one register is targeted by a single bus write
    a_r2_single_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wsel));

    // R4: no extended register strobe while the bank is locked
    a_r4_locked_no_strobe: assert property (@(posedge clk) disable iff (rst)
        !unlocked |-> !(wsel.ctl || wsel.mem_n || wsel.mem_m ||
                        wsel.pix_n || wsel.pix_m || wsel.trig));

endmodule

// File: rtl/clkbank_divider.sv
module clkbank_divider
    import clkbank_pkg::*;
#(
    parameter bit               STAGED = 1'b1,
    parameter logic [DIV_W-1:0] N_RST  = 7'h42,
    parameter logic [DIV_W-1:0] M_RST  = 7'h3D
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_n,
    input  logic             wr_m,
    input  logic [DIV_W-1:0] wdata,
    input  logic             apply,
    output logic [DIV_W-1:0] pend_n,
    output logic [DIV_W-1:0] pend_m,
    output logic [DIV_W-1:0] act_n,
    output logic [DIV_W-1:0] act_m
);

    typedef struct packed {
        logic [DIV_W-1:0] pn;
        logic [DIV_W-1:0] pm;
        logic [DIV_W-1:0] an;
        logic [DIV_W-1:0] am;
    } div_t;

    div_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_n) st_d.pn = wdata;
        if (wr_m) st_d.pm = wdata;
        if (!STAGED) begin
            st_d.an = st_d.pn;
            st_d.am = st_d.pm;
        end else if (apply) begin
            st_d.an = st_q.pn;
            st_d.am = st_q.pm;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{pn: N_RST, pm: M_RST, an: N_RST, am: M_RST};
        else     st_q <= st_d;
    end

    assign pend_n = st_q.pn;
    assign pend_m = st_q.pm;
    assign act_n  = st_q.an;
    assign act_m  = st_q.am;

    generate
        if (STAGED) begin : g_staged
            // R7: the trigger copies the pending set into the active set
            a_r7_apply_copies: assert property (@(posedge clk) disable iff (rst)
                apply |=> (act_n == $past(pend_n)) && (act_m == $past(pend_m)));
            // R6: without a trigger the active set holds
            a_r6_active_holds: assert property (@(posedge clk) disable iff (rst)
                !apply |=> $stable(act_n) && $stable(act_m));
        end
    endgenerate

endmodule

// File: rtl/clkbank_regs.sv
module clkbank_regs
    import clkbank_pkg::*;
#(
    parameter int                ADDR_W       = 10,
    parameter logic [ADDR_W-1:0] IDX_PORT     = 'h3C4,
    parameter logic [ADDR_W-1:0] DATA_PORT    = 'h3C5,
    parameter logic [ADDR_W-1:0] MISC_WR_PORT = 'h3C2,
    parameter logic [ADDR_W-1:0] MISC_RD_PORT = 'h3CC,
    parameter logic [7:0]        UNLOCK_KEY   = 8'h06,
    parameter logic [6:0]        PIX_N_RST    = 7'h42,
    parameter logic [6:0]        PIX_M_RST    = 7'h3D,
    parameter logic [6:0]        MEM_N_RST    = 7'h22,
    parameter logic [6:0]        MEM_M_RST    = 7'h3A,
    parameter logic [7:0]        CTL_RST      = 8'h01
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic [1:0]        clk_sel,
    output logic              pll_selected,
    output logic              drive_en,
    output logic [4:0]        pix_n1,
    output logic [1:0]        pix_n2,
    output logic [6:0]        pix_m,
    output logic [4:0]        mem_n1,
    output logic [1:0]        mem_n2,
    output logic [6:0]        mem_m
);

    typedef struct packed {
        logic [7:0] idx;
        logic [7:0] misc;
        logic [7:0] lock;
        logic [7:0] ctl;
        logic [7:0] trig;
    } bank_t;

    bank_t st_d, st_q;
    wsel_t wsel;
    logic  unlocked;
    logic  apply;
    logic [DIV_W-1:0] pix_pn, pix_pm, pix_an, pix_am;
    logic [DIV_W-1:0] mem_pn, mem_pm, mem_an, mem_am;

    assign unlocked = (st_q.lock == UNLOCK_KEY);

    clkbank_decode #(
        .ADDR_W(ADDR_W), .IDX_PORT(IDX_PORT), .DATA_PORT(DATA_PORT),
        .MISC_WR_PORT(MISC_WR_PORT)
    ) u_decode (
        .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr),
        .idx(st_q.idx), .unlocked(unlocked), .wsel(wsel)
    );

    // trigger completes when a set bit 5 is written back to 0
    assign apply = wsel.trig && st_q.trig[TRIG_BIT] && !bus_wdata[TRIG_BIT];

    clkbank_divider #(.STAGED(1'b1), .N_RST(PIX_N_RST), .M_RST(PIX_M_RST)) u_pix (
        .clk(clk), .rst(rst), .wr_n(wsel.pix_n), .wr_m(wsel.pix_m),
        .wdata(bus_wdata[DIV_W-1:0]), .apply(apply),
        .pend_n(pix_pn), .pend_m(pix_pm), .act_n(pix_an), .act_m(pix_am)
    );

    clkbank_divider #(.STAGED(1'b0), .N_RST(MEM_N_RST), .M_RST(MEM_M_RST)) u_mem (
        .clk(clk), .rst(rst), .wr_n(wsel.mem_n), .wr_m(wsel.mem_m),
        .wdata(bus_wdata[DIV_W-1:0]), .apply(1'b0),
        .pend_n(mem_pn), .pend_m(mem_pm), .act_n(mem_an), .act_m(mem_am)
    );

    always_comb begin
        st_d = st_q;
        if (wsel.idx)  st_d.idx  = bus_wdata;
        if (wsel.misc) st_d.misc = bus_wdata;
        if (wsel.lock) st_d.lock = bus_wdata;
        if (wsel.ctl)  st_d.ctl  = bus_wdata;
        if (wsel.trig) st_d.trig = bus_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{idx: 8'h00, misc: 8'h00, lock: 8'h00, ctl: CTL_RST, trig: 8'h00};
        else     st_q <= st_d;
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_addr == IDX_PORT) begin
            bus_rdata = st_q.idx;
        end else if (bus_addr == MISC_RD_PORT) begin
            bus_rdata = st_q.misc;
        end else if (bus_addr == DATA_PORT) begin
            if (st_q.idx == IDX_LOCK) begin
                bus_rdata = st_q.lock;
            end else if (unlocked) begin
                case (st_q.idx)
                    IDX_CTL:   bus_rdata = st_q.ctl;
                    IDX_MEM_N: bus_rdata = {1'b0, mem_pn};
                    IDX_MEM_M: bus_rdata = {1'b0, mem_pm};
                    IDX_PIX_N: bus_rdata = {1'b0, pix_pn};
                    IDX_PIX_M: bus_rdata = {1'b0, pix_pm};
                    IDX_TRIG:  bus_rdata = st_q.trig;
                    default:   bus_rdata = 8'h00;
                endcase
            end
        end
    end

    assign clk_sel      = st_q.misc[3:2];
    assign pll_selected = (st_q.misc[3:2] == 2'b11);
    assign drive_en     = !st_q.ctl[0];
    assign pix_n1       = pix_an[4:0];
    assign pix_n2       = pix_an[6:5];
    assign pix_m        = pix_am;
    assign mem_n1       = mem_an[4:0];
    assign mem_n2       = mem_an[6:5];
    assign mem_m        = mem_am;

    // R4: locked data writes leave every divider register untouched
    a_r4_locked_ignored: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == DATA_PORT && !unlocked && st_q.idx != IDX_LOCK)
        |=> $stable(pix_pn) && $stable(pix_pm) && $stable(mem_pn) && $stable(mem_pm));

    // R9: the clock select moves only after a miscellaneous write
    a_r9_sel_hold: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == MISC_WR_PORT) |=> $stable(clk_sel));

endmodule

// File: tb/clkbank_regs_test.sv
module clkbank_regs_test;

    localparam int   CLK_PERIOD = 10;
    localparam logic [9:0] A_IDX  = 10'h3C4;
    localparam logic [9:0] A_DATA = 10'h3C5;
    localparam logic [9:0] A_MW   = 10'h3C2;
    localparam logic [9:0] A_MR   = 10'h3CC;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [9:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] clk_sel;
    logic       pll_selected, drive_en;
    logic [4:0] pix_n1, mem_n1;
    logic [1:0] pix_n2, mem_n2;
    logic [6:0] pix_m, mem_m;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    // behavioural model state
    byte unsigned m_idx, m_misc, m_lock, m_ctl, m_trig;
    byte unsigned m_pn, m_pm, m_an, m_am, m_mn, m_mm;

    clkbank_regs uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_sel(clk_sel),
        .pll_selected(pll_selected), .drive_en(drive_en),
        .pix_n1(pix_n1), .pix_n2(pix_n2), .pix_m(pix_m),
        .mem_n1(mem_n1), .mem_n2(mem_n2), .mem_m(mem_m)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit m_open();
        return m_lock == 8'h06;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_idx = 0; m_misc = 0; m_lock = 0; m_ctl = 8'h01; m_trig = 0;
            m_pn = 8'h42; m_pm = 8'h3D; m_an = 8'h42; m_am = 8'h3D;
            m_mn = 8'h22; m_mm = 8'h3A;
        end else if (bus_wr) begin
            if (bus_addr == A_IDX) m_idx = bus_wdata;
            else if (bus_addr == A_MW) m_misc = bus_wdata;
            else if (bus_addr == A_DATA) begin
                if (m_idx == 8'h08) m_lock = bus_wdata;
                else if (m_open()) begin
                    case (m_idx)
                        8'h0D: m_ctl = bus_wdata;
                        8'h10: m_mn = bus_wdata & 8'h7F;
                        8'h11: m_mm = bus_wdata & 8'h7F;
                        8'h12: m_pn = bus_wdata & 8'h7F;
                        8'h13: m_pm = bus_wdata & 8'h7F;
                        8'h15: begin
                            if (m_trig[5] && !bus_wdata[5]) begin
                                m_an = m_pn; m_am = m_pm;
                            end
                            m_trig = bus_wdata;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    function automatic byte unsigned exp_read(logic [9:0] a);
        if (a == A_IDX) return m_idx;
        if (a == A_MR) return m_misc;
        if (a != A_DATA) return 0;
        if (m_idx == 8'h08) return m_lock;
        if (!m_open()) return 0;
        case (m_idx)
            8'h0D: return m_ctl;
            8'h10: return m_mn;
            8'h11: return m_mm;
            8'h12: return m_pn;
            8'h13: return m_pm;
            8'h15: return m_trig;
            default: return 0;
        endcase
    endfunction

    task automatic chk(string what, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got 0x%02h expected 0x%02h at %0t", cur_req, what, got, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("rdata", bus_rdata, exp_read(bus_addr));
        chk("clk_sel R9", {6'b0, clk_sel}, {6'b0, m_misc[3:2]});
        chk("pll_selected R9", {7'b0, pll_selected}, {7'b0, m_misc[3:2] == 2'b11});
        chk("drive_en R10", {7'b0, drive_en}, {7'b0, !m_ctl[0]});
        chk("pix_n R7", {1'b0, pix_n2, pix_n1}, m_an);
        chk("pix_m R7", {1'b0, pix_m}, m_am);
        chk("mem_n R5", {1'b0, mem_n2, mem_n1}, m_mn);
        chk("mem_m R5", {1'b0, mem_m}, m_mm);
    endtask

    task automatic op(bit w, logic [9:0] a, logic [7:0] d);
        @(negedge clk);
        compare_all();
        bus_wr = w; bus_addr = a; bus_wdata = d;
    endtask

    task automatic wreg(logic [7:0] i, logic [7:0] d);
        op(1, A_IDX, i);
        op(1, A_DATA, d);
        op(0, A_DATA, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset values against fixed numbers
        @(negedge clk);
        cur_req = "R1";
        chk("reset clk_sel", {6'b0, clk_sel}, 8'h00);
        chk("reset pix_n", {1'b0, pix_n2, pix_n1}, 8'h42);
        chk("reset mem_m", {1'b0, mem_m}, 8'h3A);
        chk("reset drive_en", {7'b0, drive_en}, 8'h00);
        op(0, A_IDX, 0);
        cur_req = "R4";
        op(1, A_IDX, 8'h10);
        op(0, A_IDX, 0);        // R2 index readback
        op(0, A_DATA, 0);       // locked read gives 0
        op(1, A_DATA, 8'h55);   // ignored
        op(0, A_DATA, 0);
        wreg(8'h15, 8'h20);     // locked trigger attempt
        wreg(8'h15, 8'h00);
        cur_req = "R3";
        wreg(8'h08, 8'h07);     // near-miss key
        wreg(8'h10, 8'h11);
        wreg(8'h08, 8'h06);
        op(1, A_IDX, 8'h10);
        op(0, A_DATA, 0);       // default survives locked writes
        cur_req = "R5";
        wreg(8'h10, 8'h2B);
        wreg(8'h11, 8'h45);
        cur_req = "R8";
        wreg(8'h11, 8'hFF);
        wreg(8'h12, 8'h80);
        cur_req = "R6";
        wreg(8'h12, 8'h61);
        wreg(8'h13, 8'h7E);
        cur_req = "R7";
        wreg(8'h15, 8'h00);     // stays 0: no copy
        wreg(8'h15, 8'h20);
        wreg(8'h15, 8'h24);     // stays 1: no copy
        wreg(8'h15, 8'h04);     // falls: copy
        wreg(8'h12, 8'h1F);
        wreg(8'h15, 8'h20);
        wreg(8'h15, 8'h00);
        cur_req = "R9";
        op(1, A_MW, 8'h0C);
        op(0, A_MR, 0);
        op(0, A_MW, 0);
        op(1, A_MW, 8'h04);
        op(0, A_MR, 0);
        op(1, A_MW, 8'hF8);
        op(0, A_MR, 0);
        cur_req = "R10";
        wreg(8'h0D, 8'h00);
        wreg(8'h0D, 8'hA1);
        wreg(8'h0D, 8'hFE);
        cur_req = "R4";
        wreg(8'h20, 8'h99);     // unimplemented index
        cur_req = "R2";
        op(1, A_IDX, 8'h13);
        op(0, A_IDX, 0);
        op(0, A_DATA, 0);
        cur_req = "R3";
        wreg(8'h08, 8'h00);
        op(1, A_IDX, 8'h12);
        op(0, A_DATA, 0);
        op(1, A_DATA, 8'h33);
        op(0, A_DATA, 0);
        @(negedge clk);
        compare_all();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule